// File: doc/BRIEF.md
# Multi-lane justified serial audio transmitter

This block is a clock-master serial audio transmitter. It accepts one parallel frame of PCM samples for up to eight channels, spreads the channels over up to four stereo data lanes, and shifts each sample out MSB first inside a fixed 32-bit channel slot. The word length (16, 18, 20 or 24 bits) and the placement of the word in the slot (left- or right-justified) can be selected. The block makes all of its own clocks from the system clock. The system clock runs at twice the oversampling rate. From it the block derives an oversampling clock at 256 times the sample rate, a bit clock at 64 times the sample rate, and a word-select that marks the left and right slots.

A producer presents a new frame with a one-cycle valid strobe whenever it has one. The block holds the most recent frame and moves it to the output at the next frame start. If no new frame has arrived by then, it sends the previous frame again. The word length, justification and active lane count are sampled at each frame start, so a frame on the wire is never split across two settings.

Top module: `pcm_lane_serializer`

## Requirements
- R1: Every channel slot lasts exactly 32 bit-clock periods. Word-select is low for the left slot (first 32 bits of a frame) and high for the right slot, so a frame is 64 bit clocks long.
- R2: The oversampling clock toggles on every system clock, which gives four oversampling periods per bit-clock period (256 per frame).
- R3: Serial data and word-select change only when the bit clock falls. A receiver samples them on the rising bit-clock edge. All active lanes share the one bit clock and word-select.
- R4: The word-length code selects 16, 18, 20 or 24 bits for codes 0, 1, 2 and 3. Only the low W bits of each 24-bit channel field are sent, and the bits above them have no effect on the output.
- R5: With the justify input at 0 (left-justified), bit W-1 of the word goes out in the first bit of the slot, followed by the lower bits in descending order. The remaining slot bits are zero.
- R6: With the justify input at 1 (right-justified), bit 0 of the word goes out in the last (32nd) bit of the slot, the word occupies the last W bit positions MSB first, and the leading bits are zero.
- R7: Channel c sits in bits [24c+23:24c] of the sample bus. Lane n carries channel 2n in its left slot and channel 2n+1 in its right slot.
- R8: A lane-count code k enables lanes 0 to k. Every lane above k is held low for the whole frame.
- R9: A frame offered with the valid strobe goes out starting at the next frame start. Configuration inputs are sampled at that same boundary. If no valid strobe occurs during a frame, the next frame repeats the held samples, and sample-bus changes without the strobe have no effect.
- R10: During reset all clock outputs, word-select and data lanes are low. The first frame after reset carries all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, twice the oversampling clock rate |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | One-cycle strobe that captures the sample bus |
| inSamples | input | 192 | Eight 24-bit channel fields, channel c at bits [24c+23:24c] |
| wordLenSel | input | 2 | Word length code: 0=16, 1=18, 2=20, 3=24 bits |
| rightJustify | input | 1 | 0 = left-justified, 1 = right-justified |
| laneCountSel | input | 2 | Highest active lane index |
| mclk | output | 1 | Oversampling clock, 256 times the sample rate |
| bclk | output | 1 | Bit clock, 64 times the sample rate |
| ws | output | 1 | Word-select, low for left slot, high for right slot |
| sd | output | 4 | Serial data lanes |

## Verification
The bench uses the default parameters: four lanes and four oversampling periods per bit clock. At that size, every combination of word length, justification and lane count (32 in all) can be swept, each with fresh samples on all eight channels. Every bit of every lane in a whole frame is predicted arithmetically and compared, and a sample-bus change without the strobe shows that the frame is repeated. A frame monitor checks slot length, oversampling clock count per bit and edge alignment across the whole run.

// File: rtl/pcm_ser_pkg.sv
package pcm_ser_pkg;
  localparam int SLOT_BITS = 32;
  localparam int SLOT_W    = $clog2(SLOT_BITS);
  localparam int WORD_MAX  = 24;

  typedef struct packed {
    logic              frameLoad;  // last system cycle of a frame
    logic              rightSlot;  // second half of the frame
    logic [SLOT_W-1:0] slotBit;    // bit position inside the current slot
  } ser_strobe_t;

  function automatic logic [SLOT_W:0] wordBits(input logic [1:0] sel);
    case (sel)
      2'd0:    wordBits = (SLOT_W+1)'(16);
      2'd1:    wordBits = (SLOT_W+1)'(18);
      2'd2:    wordBits = (SLOT_W+1)'(20);
      default: wordBits = (SLOT_W+1)'(24);
    endcase
  endfunction
endpackage

// File: rtl/pcm_ser_ctrl.sv
module pcm_ser_ctrl
  import pcm_ser_pkg::*;
#(
  parameter int MCLK_PER_BCLK = 4
) (
  input  logic        clk,
  input  logic        rstN,
  output ser_strobe_t strb,
  output logic        mclk,
  output logic        bclk,
  output logic        ws
);
  localparam int PH_W    = $clog2(2 * MCLK_PER_BCLK);
  localparam int FRAME_W = $clog2(2 * SLOT_BITS);
  localparam int CNT_W   = PH_W + FRAME_W;

  logic [CNT_W-1:0] phaseCnt;

  always_ff @(posedge clk) begin
    if (!rstN) phaseCnt <= '0;
    else       phaseCnt <= phaseCnt + 1'b1;
  end

  assign mclk = phaseCnt[0];
  assign bclk = phaseCnt[PH_W-1];
  assign ws   = phaseCnt[CNT_W-1];

  assign strb.frameLoad = &phaseCnt;
  assign strb.rightSlot = phaseCnt[CNT_W-1];
  assign strb.slotBit   = phaseCnt[CNT_W-2:PH_W];
endmodule

// File: rtl/pcm_ser_datapath.sv
module pcm_ser_datapath
  import pcm_ser_pkg::*;
#(
  parameter int NUM_LANES = 4,
  parameter int LSEL_W    = 2
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  ser_strobe_t                     strb,
  input  logic                            inValid,
  input  logic [2*NUM_LANES*WORD_MAX-1:0] inSamples,
  input  logic [1:0]                      wordLenSel,
  input  logic                            rightJustify,
  input  logic [LSEL_W-1:0]               laneCountSel,
  output logic [NUM_LANES-1:0]            sd
);
  localparam int NUM_CH = 2 * NUM_LANES;
  localparam int PW     = SLOT_W + 1;

  logic [NUM_CH*WORD_MAX-1:0] pendSamples;
  logic [NUM_CH*WORD_MAX-1:0] actSamples;
  logic [1:0]                 actWl;
  logic                       actRj;
  logic [LSEL_W-1:0]          actLanes;
  logic [PW-1:0]              wBits;

  always_ff @(posedge clk) begin
    if (!rstN)        pendSamples <= '0;
    else if (inValid) pendSamples <= inSamples;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      actSamples <= '0;
      actWl      <= '0;
      actRj      <= 1'b0;
      actLanes   <= '0;
    end else if (strb.frameLoad) begin
      actSamples <= pendSamples;
      actWl      <= wordLenSel;
      actRj      <= rightJustify;
      actLanes   <= laneCountSel;
    end
  end

  assign wBits = wordBits(actWl);

  for (genvar l = 0; l < NUM_LANES; l++) begin : gLane
    logic [SLOT_BITS-1:0] wordPad;
    logic [PW-1:0]        pos;
    logic [SLOT_W-1:0]    idx;
    logic                 inWord;
    logic                 laneOn;

    always_comb begin
      wordPad = '0;
      wordPad[WORD_MAX-1:0] = strb.rightSlot ? actSamples[(2*l+1)*WORD_MAX +: WORD_MAX]
                                             : actSamples[(2*l)*WORD_MAX +: WORD_MAX];
      pos = {1'b0, strb.slotBit};
      if (!actRj) begin
        inWord = pos < wBits;
        idx    = SLOT_W'(wBits - PW'(1) - pos);
      end else begin
        inWord = pos >= (PW'(SLOT_BITS) - wBits);
        idx    = SLOT_W'(SLOT_BITS - 1) - strb.slotBit;
      end
      laneOn = LSEL_W'(l) <= actLanes;
      sd[l]  = laneOn && inWord && wordPad[idx];
    end
  end
endmodule

// File: rtl/pcm_lane_serializer.sv
module pcm_lane_serializer
  import pcm_ser_pkg::*;
#(
  parameter int NUM_LANES     = 4,
  parameter int MCLK_PER_BCLK = 4
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            inValid,
  input  logic [2*NUM_LANES*WORD_MAX-1:0] inSamples,
  input  logic [1:0]                      wordLenSel,
  input  logic                            rightJustify,
  input  logic [((NUM_LANES > 1) ? $clog2(NUM_LANES) : 1)-1:0] laneCountSel,
  output logic                            mclk,
  output logic                            bclk,
  output logic                            ws,
  output logic [NUM_LANES-1:0]            sd
);
  localparam int LSEL_W = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1;

  ser_strobe_t strb;

  pcm_ser_ctrl #(.MCLK_PER_BCLK(MCLK_PER_BCLK)) uCtrl (
    .clk  (clk),
    .rstN (rstN),
    .strb (strb),
    .mclk (mclk),
    .bclk (bclk),
    .ws   (ws)
  );

  pcm_ser_datapath #(.NUM_LANES(NUM_LANES), .LSEL_W(LSEL_W)) uDp (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .inValid      (inValid),
    .inSamples    (inSamples),
    .wordLenSel   (wordLenSel),
    .rightJustify (rightJustify),
    .laneCountSel (laneCountSel),
    .sd           (sd)
  );
endmodule

// File: rtl/pcm_ser_checker.sv
module pcm_ser_checker #(
  parameter int NUM_LANES = 4,
  parameter int LSEL_W    = 2
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 mclk,
  input logic                 bclk,
  input logic                 ws,
  input logic [NUM_LANES-1:0] sd,
  input logic [LSEL_W-1:0]    laneSel
);
  logic [6:0] bitCnt;
  logic       pBclk;
  logic       pWs;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitCnt <= '0;
      pBclk  <= 1'b0;
      pWs    <= 1'b0;
    end else begin
      pBclk <= bclk;
      pWs   <= ws;
      if (ws != pWs)          bitCnt <= '0;
      else if (bclk && !pBclk) bitCnt <= bitCnt + 7'd1;
    end
  end

  AST_SLOT_WIDTH: assert property (@(posedge clk) disable iff (!rstN)
    (ws != pWs) |-> (bitCnt == 7'd32)); // R1

  AST_MCLK_TOGGLE: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> (mclk != $past(mclk))); // R2

  AST_WS_ON_FALL: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(ws) |-> $fell(bclk)); // R3

  AST_SD_ON_FALL: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sd) |-> $fell(bclk)); // R3

  for (genvar l = 0; l < NUM_LANES; l++) begin : gIdle
    AST_IDLE_LANE_LOW: assert property (@(posedge clk) disable iff (!rstN)
      (laneSel < LSEL_W'(l)) |-> !sd[l]); // R8
  end
endmodule

bind pcm_lane_serializer pcm_ser_checker #(.NUM_LANES(NUM_LANES), .LSEL_W(LSEL_W)) uChk (
  .clk     (clk),
  .rstN    (rstN),
  .mclk    (mclk),
  .bclk    (bclk),
  .ws      (ws),
  .sd      (sd),
  .laneSel (uDp.actLanes)
);

// File: tb/pcm_lane_serializer_test.sv
module pcm_lane_serializer_test;
  localparam int CLK_PERIOD = 10;
  localparam int NL   = 4;
  localparam int NCH  = 2 * NL;
  localparam int WMAX = 24;

  logic              clk = 1'b0;
  logic              rstN;
  logic              inValid;
  logic [NCH*WMAX-1:0] inSamples;
  logic [1:0]        wordLenSel;
  logic              rightJustify;
  logic [1:0]        laneCountSel;
  logic              mclk, bclk, ws;
  logic [NL-1:0]     sd;

  int nChecks = 0;
  int nFail   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pcm_lane_serializer #(.NUM_LANES(NL), .MCLK_PER_BCLK(4)) uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inSamples(inSamples),
    .wordLenSel(wordLenSel), .rightJustify(rightJustify), .laneCountSel(laneCountSel),
    .mclk(mclk), .bclk(bclk), .ws(ws), .sd(sd)
  );

  // ---------------- frame monitor ----------------
  logic [63:0] curBits [NL];
  logic [63:0] lastFrame [NL];
  int  pos = 0;
  int  frameCount = 0;
  int  mclkRise = 0;
  bit  seenBit = 0;
  logic pMclk = 0, pBclk = 0, pWsBit = 1, pWs = 0;
  logic [NL-1:0] pSd = '0;
  int  badSlot = 0, badMclk = 0, badEdge = 0;

  always @(negedge clk) begin
    if (!rstN) begin
      pos = 0; seenBit = 0; mclkRise = 0; pWsBit = 1;
      pMclk = 0; pBclk = 0; pWs = 0; pSd = '0;
    end else begin
      if ((sd !== pSd || ws !== pWs) && !(pBclk && !bclk)) badEdge++;
      if (mclk && !pMclk) mclkRise++;
      if (bclk && !pBclk) begin
        if (seenBit && mclkRise != 4) badMclk++;
        mclkRise = 0;
        seenBit  = 1;
        if (!ws && pWsBit) pos = 0;
        pWsBit = ws;
        if (pos > 63) badSlot++;
        else begin
          if (ws !== (pos >= 32)) badSlot++;
          for (int l = 0; l < NL; l++) curBits[l][pos] = sd[l];
          pos++;
          if (pos == 64) begin
            for (int l = 0; l < NL; l++) lastFrame[l] = curBits[l];
            frameCount++;
          end
        end
      end
      pMclk = mclk; pBclk = bclk; pWs = ws; pSd = sd;
    end
  end

  // ---------------- helpers ----------------
  logic [WMAX-1:0] expSamp [NCH];

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] expLane(input int lane, input int wl, input int rj, input int ls);
    logic [63:0] r = '0;
    int w;
    w = (wl == 0) ? 16 : (wl == 1) ? 18 : (wl == 2) ? 20 : 24;
    if (lane > ls) return '0;
    for (int p = 0; p < 64; p++) begin
      int b = p % 32;
      logic [WMAX-1:0] d = expSamp[2*lane + ((p >= 32) ? 1 : 0)];
      if (rj == 0) r[p] = (b < w) ? d[w-1-b] : 1'b0;
      else         r[p] = (b >= 32 - w) ? d[31-b] : 1'b0;
    end
    return r;
  endfunction

  task automatic runFrame(input int wl, input int rj, input int ls, input bit pulse);
    int fc;
    wait (pos == 2);
    @(negedge clk);
    wordLenSel   = 2'(wl);
    rightJustify = rj[0];
    laneCountSel = 2'(ls);
    for (int c = 0; c < NCH; c++) begin
      logic [WMAX-1:0] v = WMAX'($urandom);
      inSamples[c*WMAX +: WMAX] = v;
      if (pulse) expSamp[c] = v;
    end
    inValid = pulse;
    @(negedge clk);
    inValid = 1'b0;
    fc = frameCount;
    wait (frameCount == fc + 2);
    for (int l = 0; l < NL; l++) begin
      string tag;
      if (!pulse) tag = $sformatf("R9 repeat lane %0d", l);
      else if (rj == 0) tag = $sformatf("R5/R4/R7/R8 wl=%0d lanes=%0d lane %0d", wl, ls, l);
      else tag = $sformatf("R6/R4/R7/R8 wl=%0d lanes=%0d lane %0d", wl, ls, l);
      check(tag, lastFrame[l], expLane(l, wl, rj, ls));
    end
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

  // ---------------- stimulus ----------------
  initial begin
    rstN = 1'b0; inValid = 1'b0; inSamples = '0;
    wordLenSel = 2'd0; rightJustify = 1'b0; laneCountSel = 2'd3;
    for (int c = 0; c < NCH; c++) expSamp[c] = '0;
    repeat (3) @(negedge clk);
    check("R10 reset outputs", 64'({mclk, bclk, ws, sd}), 64'd0);
    rstN = 1'b1;

    wait (frameCount == 1);
    for (int l = 0; l < NL; l++) check($sformatf("R10 first frame lane %0d", l), lastFrame[l], 64'd0);

    for (int wl = 0; wl < 4; wl++)
      for (int rj = 0; rj < 2; rj++)
        for (int ls = 0; ls < 4; ls++)
          runFrame(wl, rj, ls, 1'b1);

    runFrame(3, 1, 3, 1'b0);
    runFrame(1, 0, 2, 1'b0);

    check("R1 slot width and ws level", 64'(badSlot), 64'd0);
    check("R2 mclk periods per bit", 64'(badMclk), 64'd0);
    check("R3 changes on bclk fall", 64'(badEdge), 64'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end
endmodule